// File: doc/BRIEF.md
# Inter-VM doorbell register block

This block is the register front end of a shared-memory device through which guests on separate hosts signal one another. A 32-bit register bus reaches four word registers: an interrupt mask, an interrupt status, the local peer's position number, and a doorbell. Writing the doorbell names a destination peer and a vector. The block looks up how many vectors that peer has registered. A well-formed request leaves the block as a one-cycle notify pulse. A request that is out of range is dropped without any trace.

Events arriving for the local peer are handled according to a mode input. With message-signalled mode off, an event sets the status register to 1, and a level interrupt output follows the masked status. With the mode on, an event becomes a per-vector message request, but only while message interrupts are enabled. The table of per-peer vector counts is loaded through a sideband port.

Top module: `dbell_regblk`

## Requirements
- R1: Word offsets are decoded as follows. 0x00 is the interrupt mask (read/write). 0x04 is the interrupt status. 0x08 returns the local position number `own_id`, zero-extended; writes to it are ignored. 0x0C is the doorbell and reads back as 0.
- R2: Only accesses with `req_be` equal to 4'hF take effect. Other writes are ignored. Other reads return 0 and leave the status untouched.
- R3: Writes are decoded on `req_addr[7:2]` only, so a write to 0x0D reaches the doorbell. Reads are decoded on the full byte address, so an unaligned read such as 0x01 returns 0.
- R4: A doorbell write takes the destination peer from bits 31:16 and the vector from bits 7:0. If accepted, `notify_valid` is high for exactly one cycle, on the cycle after the write, with `notify_peer` and `notify_vec` carrying those fields.
- R5: A doorbell is dropped in any of these cases: the peer is not below `live_peers`, the peer is not below NUM_PEERS, or the vector is not below that peer's registered count.
- R6: A full read of the status register returns its value and clears it to zero. If a local event arrives in the same cycle, the event wins and the status becomes 1.
- R7: Reads of undecoded offsets return 0. Writes to undecoded offsets change no register.
- R8: Reset clears the mask, the status, the count table and all pulse outputs.
- R9: `irq_out` is high while (status AND mask) is nonzero. It follows a register write on the next cycle.
- R10: A local event (`evt_valid`) behaves according to the mode. With `msg_mode`=0, it sets the status to 1 on the next cycle. With `msg_mode`=1 and `msg_enable`=1, it raises `msg_req_valid` for one cycle on the next cycle, with `msg_req_vec`=`evt_vec`. With `msg_mode`=1 and `msg_enable`=0, it has no effect.
- R11: When `tbl_we` is high, the sideband port stores `tbl_cnt` as the vector count of peer `tbl_idx`. The new count governs doorbells from the next cycle.
- R12: Every read request gives `rd_valid` on the following cycle, with `rd_data` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address in the 256-byte window |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read data |
| own_id | input | 16 | Local peer position number |
| live_peers | input | 16 | Current number of peers |
| tbl_we | input | 1 | Sideband count-table write strobe |
| tbl_idx | input | IDX_W | Peer index for table write |
| tbl_cnt | input | 8 | Vector count to store |
| msg_mode | input | 1 | Message-signalled interrupt mode |
| msg_enable | input | 1 | Message interrupts enabled |
| evt_valid | input | 1 | Incoming event for the local peer |
| evt_vec | input | 8 | Vector of the incoming event |
| notify_valid | output | 1 | Accepted doorbell pulse |
| notify_peer | output | 16 | Destination peer of the pulse |
| notify_vec | output | 8 | Vector of the pulse |
| msg_req_valid | output | 1 | Per-vector message request pulse |
| msg_req_vec | output | 8 | Vector of the message request |
| irq_out | output | 1 | Level interrupt |

## Verification
Each result has one latency, and the bench samples there. Read data, notify pulses and message requests are registered, so they are due one cycle after the accepting edge. Register writes show up on `irq_out` and in later reads one cycle after the write edge. The bench drives every input on the falling edge and samples on the next falling edge, which lies half a period after the edge that produced the result. Pulse checks also confirm that the output has returned low one cycle later.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  typedef logic [15:0] peer_t;
  typedef logic [7:0]  vec_t;

  // word indices (addr[7:2]) of the decoded registers
  localparam logic [5:0] W_MASK = 6'd0;
  localparam logic [5:0] W_STAT = 6'd1;
  localparam logic [5:0] W_ID   = 6'd2;
  localparam logic [5:0] W_DB   = 6'd3;

  function automatic logic target_ok(peer_t peer, vec_t vec, peer_t live,
                                     vec_t cnt, logic inrange);
    return inrange && (peer < live) && (vec < cnt);
  endfunction

  function automatic logic [31:0] read_word(logic [7:0] addr, logic [31:0] mask,
                                            logic [31:0] stat, peer_t id);
    case (addr)
      8'h00:   return mask;
      8'h04:   return stat;
      8'h08:   return {16'h0, id};
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/dbell_vec_table.sv
module dbell_vec_table
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  localparam int IDX_W = $clog2(NUM_PEERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  vec_t             wr_cnt,
  input  peer_t            rd_peer,
  output vec_t             rd_cnt,
  output logic             rd_inrange
);
  localparam peer_t NP = peer_t'(NUM_PEERS);

  vec_t cnt_q [NUM_PEERS];

  for (genvar i = 0; i < NUM_PEERS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        cnt_q[i] <= wr_cnt;
    end
  end

  assign rd_inrange = (rd_peer < NP);
  assign rd_cnt     = rd_inrange ? cnt_q[rd_peer[IDX_W-1:0]] : '0;

  // R11: a loaded count is visible through the lookup port next cycle
  a_r11_table_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_peer == peer_t'(wr_idx) && $stable(rd_peer)) |=> (rd_cnt == $past(wr_cnt)))
    else $error("a_r11_table_load");
endmodule

// File: rtl/dbell_ring.sv
module dbell_ring
  import dbell_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  db_fire,
  input  peer_t db_peer,
  input  vec_t  db_vec,
  input  peer_t live_peers,
  input  vec_t  peer_cnt,
  input  logic  peer_inrange,
  output logic  notify_valid,
  output peer_t notify_peer,
  output vec_t  notify_vec
);
  logic accept;
  assign accept = db_fire && target_ok(db_peer, db_vec, live_peers, peer_cnt, peer_inrange);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify_valid <= 1'b0;
      notify_peer  <= '0;
      notify_vec   <= '0;
    end else begin
      notify_valid <= accept;
      if (accept) begin
        notify_peer <= db_peer;
        notify_vec  <= db_vec;
      end
    end
  end

  // R4: a pulse only follows a doorbell write on the previous edge
  a_r4_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(db_fire))
    else $error("a_r4_pulse_src");
  // R5: an emitted peer was below the live peer count
  a_r5_live_peer: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (notify_peer < $past(live_peers)))
    else $error("a_r5_live_peer");
endmodule

// File: rtl/dbell_csr.sv
module dbell_csr
  import dbell_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic [5:0]  wr_word,
  input  logic [31:0] wdata,
  input  logic        rd_req,
  input  logic        rd_full,
  input  logic [7:0]  rd_addr,
  input  peer_t       own_id,
  input  logic        msg_mode,
  input  logic        msg_enable,
  input  logic        evt_valid,
  input  vec_t        evt_vec,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        msg_req_valid,
  output vec_t        msg_req_vec,
  output logic        irq_out
);
  logic [31:0] mask_q, stat_q;
  logic evt_set, stat_rd_clr, msg_fire;

  assign evt_set     = evt_valid && !msg_mode;
  assign msg_fire    = evt_valid && msg_mode && msg_enable;
  assign stat_rd_clr = rd_req && rd_full && (rd_addr == 8'h04);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_fire && wr_word == W_MASK) mask_q <= wdata;
      if (evt_set)                           stat_q <= 32'd1;
      else if (stat_rd_clr)                  stat_q <= '0;
      else if (wr_fire && wr_word == W_STAT) stat_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      msg_req_valid <= 1'b0;
      msg_req_vec   <= '0;
    end else begin
      rd_valid      <= rd_req;
      rd_data       <= (rd_req && rd_full) ? read_word(rd_addr, mask_q, stat_q, own_id) : 32'h0;
      msg_req_valid <= msg_fire;
      if (msg_fire) msg_req_vec <= evt_vec;
    end
  end

  assign irq_out = |(stat_q & mask_q);

  // R6: a read of status with no competing event leaves it zero
  a_r6_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && !evt_set) |=> (stat_q == 32'd0))
    else $error("a_r6_rd_clear");
  // R10: a non-message event always lands as status 1
  a_r10_stat_one: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> (stat_q == 32'd1))
    else $error("a_r10_stat_one");
  // R10: message requests only when both mode and enable were set
  a_r10_msg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req_valid |-> $past(evt_valid && msg_mode && msg_enable))
    else $error("a_r10_msg_gate");
  // R9: the level interrupt needs a nonzero mask
  a_r9_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_q != 32'd0))
    else $error("a_r9_irq_mask");
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  localparam int IDX_W = $clog2(NUM_PEERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_addr,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  input  logic [15:0]      own_id,
  input  logic [15:0]      live_peers,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [7:0]       tbl_cnt,
  input  logic             msg_mode,
  input  logic             msg_enable,
  input  logic             evt_valid,
  input  logic [7:0]       evt_vec,
  output logic             notify_valid,
  output logic [15:0]      notify_peer,
  output logic [7:0]       notify_vec,
  output logic             msg_req_valid,
  output logic [7:0]       msg_req_vec,
  output logic             irq_out
);
  logic       full_acc, wr_fire, rd_req, db_fire;
  logic [5:0] wr_word;
  peer_t      db_peer;
  vec_t       db_vec, peer_cnt;
  logic       peer_inrange;

  assign full_acc = (req_be == 4'hF);
  assign wr_word  = req_addr[7:2];
  assign wr_fire  = req_valid && req_write && full_acc;
  assign rd_req   = req_valid && !req_write;
  assign db_fire  = wr_fire && (wr_word == W_DB);
  assign db_peer  = req_wdata[31:16];
  assign db_vec   = req_wdata[7:0];

  dbell_vec_table #(.NUM_PEERS(NUM_PEERS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_cnt(tbl_cnt),
    .rd_peer(db_peer), .rd_cnt(peer_cnt), .rd_inrange(peer_inrange)
  );

  dbell_ring u_ring (
    .clk(clk), .rst_n(rst_n), .db_fire(db_fire), .db_peer(db_peer), .db_vec(db_vec),
    .live_peers(live_peers), .peer_cnt(peer_cnt), .peer_inrange(peer_inrange),
    .notify_valid(notify_valid), .notify_peer(notify_peer), .notify_vec(notify_vec)
  );

  dbell_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_word(wr_word), .wdata(req_wdata),
    .rd_req(rd_req), .rd_full(full_acc), .rd_addr(req_addr), .own_id(own_id),
    .msg_mode(msg_mode), .msg_enable(msg_enable), .evt_valid(evt_valid), .evt_vec(evt_vec),
    .rd_valid(rd_valid), .rd_data(rd_data), .msg_req_valid(msg_req_valid),
    .msg_req_vec(msg_req_vec), .irq_out(irq_out)
  );

  // R2: a partial write never produces a notify pulse
  a_r2_partial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(req_be == 4'hF))
    else $error("a_r2_partial_quiet");
  // R12: read data valid follows every read request by one cycle
  a_r12_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid)
    else $error("a_r12_rd_latency");
endmodule

// File: tb/sim_dbell_regblk.sv
module sim_dbell_regblk;
  localparam int NP = 16;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [3:0] req_be = 0;
  logic [31:0] req_wdata = 0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [15:0] own_id = 16'h0005, live_peers = 16'd8;
  logic tbl_we = 0;
  logic [IW-1:0] tbl_idx = 0;
  logic [7:0] tbl_cnt = 0;
  logic msg_mode = 0, msg_enable = 0, evt_valid = 0;
  logic [7:0] evt_vec = 0;
  logic notify_valid, msg_req_valid, irq_out;
  logic [15:0] notify_peer;
  logic [7:0] notify_vec, msg_req_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbell_regblk #(.NUM_PEERS(NP)) u0 (.*);

  // {accept expected, doorbell word}; peer i holds count i, live_peers = 8
  localparam logic [32:0] DB_TAB [8] = '{
    {1'b1, 16'd3,  16'h0002},
    {1'b0, 16'd3,  16'h0003},
    {1'b0, 16'd0,  16'h0000},
    {1'b1, 16'd7,  16'h0006},
    {1'b0, 16'd8,  16'h0000},
    {1'b1, 16'd5,  16'hFF04},
    {1'b0, 16'd20, 16'h0000},
    {1'b1, 16'd1,  16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic tload(input int idx, input logic [7:0] c);
    @(negedge clk);
    tbl_we = 1; tbl_idx = IW'(idx); tbl_cnt = c;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic evt(input logic [7:0] v);
    @(negedge clk);
    evt_valid = 1; evt_vec = v;
    @(negedge clk);
    evt_valid = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    chk("R8 irq", {31'd0, irq_out}, 0);
    chk("R8 notify", {31'd0, notify_valid}, 0);
    acc(0, 8'h00, 0, 4'hF); chk("R8 mask", rd_data, 0);
    chk("R12 rd_valid", {31'd0, rd_valid}, 1);
    acc(0, 8'h04, 0, 4'hF); chk("R8 status", rd_data, 0);

    // R1 decode
    acc(0, 8'h08, 0, 4'hF); chk("R1 own id", rd_data, 32'h5);
    acc(1, 8'h08, 32'h1234, 4'hF);
    acc(0, 8'h08, 0, 4'hF); chk("R1 id read-only", rd_data, 32'h5);
    acc(1, 8'h00, 32'hA5A5_0F0F, 4'hF);
    acc(0, 8'h00, 0, 4'hF); chk("R1 mask rw", rd_data, 32'hA5A5_0F0F);
    acc(0, 8'h0C, 0, 4'hF); chk("R1 doorbell reads 0", rd_data, 0);

    // R7 undecoded
    acc(0, 8'h10, 0, 4'hF); chk("R7 undecoded read", rd_data, 0);
    acc(1, 8'h20, 32'hFFFF_FFFF, 4'hF);
    acc(0, 8'h00, 0, 4'hF); chk("R7 write ignored mask", rd_data, 32'hA5A5_0F0F);
    acc(0, 8'h04, 0, 4'hF); chk("R7 write ignored status", rd_data, 0);

    // R11 table load, then R4/R5 vector walk
    for (int i = 0; i < NP; i++) tload(i, 8'(i));
    foreach (DB_TAB[k]) begin
      acc(1, 8'h0C, DB_TAB[k][31:0], 4'hF);
      chk("R5 accept", {31'd0, notify_valid}, {31'd0, DB_TAB[k][32]});
      if (DB_TAB[k][32]) begin
        chk("R4 peer", {16'd0, notify_peer}, {16'd0, DB_TAB[k][31:16]});
        chk("R4 vec", {24'd0, notify_vec}, {24'd0, DB_TAB[k][7:0]});
      end
      @(negedge clk);
      chk("R4 one cycle", {31'd0, notify_valid}, 0);
    end

    // R3 write decode on addr[7:2], read decode on full address
    acc(1, 8'h0D, {16'd3, 16'd0}, 4'hF);
    chk("R3 alias doorbell", {31'd0, notify_valid}, 1);
    acc(0, 8'h01, 0, 4'hF); chk("R3 unaligned read", rd_data, 0);

    // R2 partial accesses
    acc(1, 8'h00, 32'h0, 4'h3);
    acc(0, 8'h00, 0, 4'hF); chk("R2 partial write", rd_data, 32'hA5A5_0F0F);
    acc(1, 8'h0C, {16'd3, 16'd1}, 4'h7);
    chk("R2 partial doorbell", {31'd0, notify_valid}, 0);

    // R9 irq
    acc(1, 8'h00, 32'h1, 4'hF);
    acc(1, 8'h04, 32'h1, 4'hF);
    chk("R9 irq high", {31'd0, irq_out}, 1);
    acc(0, 8'h04, 0, 4'h1); chk("R2 partial read", rd_data, 0);
    chk("R2 no clear", {31'd0, irq_out}, 1);

    // R6 read clears
    acc(0, 8'h04, 0, 4'hF); chk("R6 read value", rd_data, 1);
    chk("R9 irq low", {31'd0, irq_out}, 0);
    acc(0, 8'h04, 0, 4'hF); chk("R6 cleared", rd_data, 0);

    // R10 events
    evt(8'd2);
    chk("R10 status set", {31'd0, irq_out}, 1);
    chk("R10 no msg", {31'd0, msg_req_valid}, 0);
    acc(0, 8'h04, 0, 4'hF); chk("R10 status one", rd_data, 1);
    msg_mode = 1; msg_enable = 1;
    evt(8'd5);
    chk("R10 msg pulse", {31'd0, msg_req_valid}, 1);
    chk("R10 msg vec", {24'd0, msg_req_vec}, 5);
    @(negedge clk);
    chk("R10 msg one cycle", {31'd0, msg_req_valid}, 0);
    acc(0, 8'h04, 0, 4'hF); chk("R10 msg leaves status", rd_data, 0);
    msg_enable = 0;
    evt(8'd6);
    chk("R10 disabled no msg", {31'd0, msg_req_valid}, 0);
    acc(0, 8'h04, 0, 4'hF); chk("R10 disabled status", rd_data, 0);
    msg_mode = 0;

    // R6 event wins over read-clear
    acc(1, 8'h04, 32'h7, 4'hF);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h04; req_be = 4'hF;
    evt_valid = 1; evt_vec = 0;
    @(negedge clk);
    req_valid = 0; evt_valid = 0;
    chk("R6 tie old value", rd_data, 7);
    acc(0, 8'h04, 0, 4'hF); chk("R6 tie event wins", rd_data, 1);

    // R11 reload drops a previously valid target
    tload(3, 8'd0);
    acc(1, 8'h0C, {16'd3, 16'd0}, 4'hF);
    chk("R11 reload drop", {31'd0, notify_valid}, 0);

    // R8 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    acc(0, 8'h00, 0, 4'hF); chk("R8 mask after reset", rd_data, 0);
    acc(1, 8'h0C, {16'd1, 16'd0}, 4'hF);
    chk("R8 table cleared", {31'd0, notify_valid}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule